// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Protocol Engine

This block is the bus-facing controller of a serial EEPROM slave. It oversamples the two-wire clock and data lines with the system clock, recognises START and STOP conditions, shifts bytes in and out, and pulls the open-drain data line low to acknowledge or to send a zero bit. It decodes the device address byte, whose upper nibble is fixed and whose remaining bits carry strap-matched select bits, page bits that extend the word address, and the read/write flag.

The engine keeps the word-address counter. It runs current-address, random (dummy write then repeated START) and sequential reads against a synchronous byte array held inside the block. Each data byte received in a write transfer is handed to a neighbouring write-commit block as an address/data strobe. That neighbour owns page buffering and write-cycle timing, reports a busy flag, and writes committed bytes into the array through a dedicated port. While busy is high the engine refuses its device address, so a master can poll for write completion.

The array holds `MEM_BYTES` bytes (512 or 1024). With 512 bytes, device-byte bits [3:2] are compared with the strap inputs and bit [1] is the page bit. With 1024 bytes, bit [3] is compared and bits [2:1] are page bits. Bit [0] is 1 for a read and 0 for a write.

Top module: `twi_eeprom_engine`

## Requirements
- R1: A falling data edge while the clock is high is a START. A rising data edge while the clock is high is a STOP. After a STOP the engine is idle with the data line released.
- R2: Input bits are sampled on the clock rising edge, most significant bit first. The engine's own drive on the data line changes only while the clock is low, after a falling edge.
- R3: A device byte acknowledges with data held low during the ninth clock only when bits [7:4] are 1010 and the select bits equal the strap inputs. Otherwise the data line stays released until the next START, including the acknowledge slots of later bytes.
- R4: While wr_busy is high the device byte is not acknowledged. Once busy is low the same byte is acknowledged.
- R5: After a write-type device byte, the next byte is acknowledged and loads the word-address counter with {page bits, that byte}.
- R6: Every further byte of a write transfer is acknowledged and emits a one-cycle byte_valid with byte_addr set to the counter and byte_data set to the byte. Only the counter's low 4 bits then increment, wrapping within the 16-byte page.
- R7: A read-type device byte is acknowledged, and the byte at the counter is returned. After each byte sent, the counter holds that byte's address plus one, so a later current-address read continues from there.
- R8: A read continues with the next byte while the master acknowledges, and ends on a master not-acknowledge. The read address wraps from the last array byte to byte 0.
- R9: A START in any state abandons the current transfer and begins a new device-byte phase without loading the counter.
- R10: The sequence START, nine clocks with data high, START, STOP leaves the engine idle with the data line released. This holds even when it interrupts a write transfer.
- R11: A byte written through the mem_we commit port is returned by a later read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND bus) |
| sda_oe | output | 1 | Pull data line low when 1 |
| strap_i | input | STRAP_W (2) | Hard-wired select inputs compared with the device byte |
| wr_busy | input | 1 | Neighbour's internal write cycle in progress |
| byte_valid | output | 1 | One-cycle strobe for a received write data byte |
| byte_addr | output | ADDR_W (9) | Array address of the strobed byte |
| byte_data | output | 8 | Strobed data byte |
| mem_we | input | 1 | Commit write enable from the neighbour |
| mem_waddr | input | ADDR_W (9) | Commit address |
| mem_wdata | input | 8 | Commit data |

## Verification
The bench targets the address wrap points. A page write that crosses a 16-byte boundary must revisit the page start, while a read that passes the last byte must continue at address 0. A design that confused the two would strobe the wrong byte_addr or return the wrong byte after the wrap. It checks the counter between transfers with current-address reads, which would expose an off-by-one increment or a counter loaded by an aborted address phase. Refusal cases are also covered: a wrong prefix, a wrong strap, and a busy neighbour must each leave the acknowledge slot high, and a design that acknowledged anyway would break write polling and claim other devices' addresses. The software-reset and mid-byte START sequences are run from partly shifted bytes, where a design that kept stale bit counts would mis-frame the next device byte.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

    // Fixed upper nibble every device byte must carry
    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    // Transfer phases of the protocol engine
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_ACK,
        ST_IGNORE
    } eng_state_t;

endpackage

// File: rtl/twi_line_sync.sv
// Line synchronizer and bus-event detector.
// Brings the clock and data lines into the system clock domain through two
// flops each, then compares with a third stage to produce single-cycle
// rising/falling clock events and START/STOP conditions.
// Assumes the system clock is many times faster than the bus clock.
module twi_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic [1:0] scl_meta, sda_meta;
    logic       scl_prev, sda_prev;

    // Two-stage synchronizers plus one history stage, idle-high reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_meta <= 2'b11;
            sda_meta <= 2'b11;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_meta <= {scl_meta[0], scl_i};
            sda_meta <= {sda_meta[0], sda_i};
            scl_prev <= scl_meta[1];
            sda_prev <= sda_meta[1];
        end
    end

    // Event decode from the synchronized level and its previous value
    always_comb begin
        scl_lvl   = scl_meta[1];
        sda_lvl   = sda_meta[1];
        scl_rise  = scl_lvl & ~scl_prev;
        scl_fall  = ~scl_lvl & scl_prev;
        start_evt = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        stop_evt  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end

    assert_events_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_evt, stop_evt, scl_rise, scl_fall}));

endmodule

// File: rtl/twi_byte_ram.sv
// Synchronous byte array with one write port and one registered read port.
// Stands in for the nonvolatile array; the write port belongs to the
// neighbouring commit block. Read data appears one cycle after the address.
module twi_byte_ram #(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);

    logic [7:0] cells [DEPTH];

    // Write on enable, always read the addressed cell
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
        rdata <= cells[raddr];
    end

endmodule

// File: rtl/twi_proto_fsm.sv
// Protocol state machine for the EEPROM slave.
// Consumes synchronized bus events, decodes the device byte, keeps the word
// address counter, acknowledges received bytes, serialises read data and
// emits a strobe per received write data byte.
// Assumes read data for rd_addr is valid a few cycles after it changes and
// that bus events arrive no faster than one every few system cycles.
module twi_proto_fsm
    import twi_eeprom_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int PAGE_BITS = 1,
    parameter int STRAP_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [STRAP_W-1:0] strap,
    input  logic              busy,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              sda_oe,
    output logic              wr_strobe,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);

    localparam int LOW_W = 4;

    eng_state_t           state;
    logic [3:0]           bit_cnt;
    logic [7:0]           shreg;
    logic                 rw_q;
    logic                 mst_ack;
    logic [PAGE_BITS-1:0] page_q;
    logic [ADDR_W-1:0]    addr_cnt;
    logic                 dev_hit;
    logic                 byte_done;

    // Device byte match against fixed prefix and strap inputs
    always_comb begin
        dev_hit   = (shreg[7:4] == DEV_PREFIX) && (shreg[3 -: STRAP_W] == strap);
        byte_done = scl_fall && (bit_cnt == 4'd8);
        rd_addr   = addr_cnt;
    end

    // Main sequencer: framing, acknowledge, shifting and counter updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            rw_q      <= 1'b0;
            mst_ack   <= 1'b0;
            page_q    <= '0;
            addr_cnt  <= '0;
            sda_oe    <= 1'b0;
            wr_strobe <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            wr_strobe <= 1'b0;
            if (start_evt) begin
                state   <= ST_DEV;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_evt) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else begin
                case (state)
                    ST_DEV, ST_WADDR, ST_WDATA: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[6:0], sda_lvl};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (byte_done) begin
                            if (state == ST_DEV) begin
                                if (dev_hit && !busy) begin
                                    sda_oe <= 1'b1;
                                    rw_q   <= shreg[0];
                                    if (!shreg[0]) page_q <= shreg[1 +: PAGE_BITS];
                                    state  <= ST_DEV_ACK;
                                end else begin
                                    state  <= ST_IGNORE;
                                end
                            end else if (state == ST_WADDR) begin
                                addr_cnt <= {page_q, shreg};
                                sda_oe   <= 1'b1;
                                state    <= ST_WADDR_ACK;
                            end else begin
                                wr_strobe <= 1'b1;
                                wr_addr   <= addr_cnt;
                                wr_data   <= shreg;
                                addr_cnt  <= {addr_cnt[ADDR_W-1:LOW_W],
                                              addr_cnt[LOW_W-1:0] + 4'd1};
                                sda_oe    <= 1'b1;
                                state     <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_DEV_ACK, ST_RD_ACK: begin
                        if (scl_rise) begin
                            mst_ack <= ~sda_lvl;
                        end else if (scl_fall) begin
                            bit_cnt <= '0;
                            if (state == ST_DEV_ACK && !rw_q) begin
                                sda_oe <= 1'b0;
                                state  <= ST_WADDR;
                            end else if (state == ST_DEV_ACK || mst_ack) begin
                                shreg    <= rd_data;
                                sda_oe   <= ~rd_data[7];
                                addr_cnt <= addr_cnt + 1'b1;
                                state    <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_IGNORE;
                            end
                        end
                    end
                    ST_WADDR_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            state   <= (state == ST_WADDR_ACK) ? ST_WDATA : ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (byte_done) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RD_ACK;
                        end else if (scl_fall) begin
                            shreg  <= {shreg[6:0], 1'b0};
                            sda_oe <= ~shreg[6];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2: own drive never changes while the clock is high
    assert_oe_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_lvl);

    // R4: a busy neighbour blocks the device acknowledge
    assert_busy_nak_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV && byte_done && busy) |=> !sda_oe);

    // R1: STOP releases the line and idles
    assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (!sda_oe && state == ST_IDLE));

    // R6: write strobe is a single-cycle pulse
    assert_strobe_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !wr_strobe);

    // R6: counter stays inside the page of the strobed byte
    assert_page_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> (addr_cnt[ADDR_W-1:LOW_W] == wr_addr[ADDR_W-1:LOW_W]));

endmodule

// File: rtl/twi_eeprom_engine.sv
// Top of the two-wire EEPROM slave engine.
// Joins the line synchronizer, the protocol state machine and the byte
// array. The commit port writes the array on behalf of the neighbouring
// write-cycle block; received write bytes leave on the strobe outputs.
// Assumes MEM_BYTES is 512 or 1024.
module twi_eeprom_engine #(
    parameter int MEM_BYTES = 512,
    localparam int ADDR_W    = $clog2(MEM_BYTES),
    localparam int PAGE_BITS = ADDR_W - 8,
    localparam int STRAP_W   = 3 - PAGE_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               wr_busy,
    output logic               byte_valid,
    output logic [ADDR_W-1:0]  byte_addr,
    output logic [7:0]         byte_data,
    input  logic               mem_we,
    input  logic [ADDR_W-1:0]  mem_waddr,
    input  logic [7:0]         mem_wdata
);

    logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data;

    twi_line_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    twi_proto_fsm #(
        .ADDR_W    (ADDR_W),
        .PAGE_BITS (PAGE_BITS),
        .STRAP_W   (STRAP_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .strap     (strap_i),
        .busy      (wr_busy),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .sda_oe    (sda_oe),
        .wr_strobe (byte_valid),
        .wr_addr   (byte_addr),
        .wr_data   (byte_data)
    );

    twi_byte_ram #(
        .DEPTH  (MEM_BYTES),
        .ADDR_W (ADDR_W)
    ) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

endmodule

// File: tb/tb_twi_eeprom_engine.sv
module tb_twi_eeprom_engine;

    localparam int H = 16;
    localparam logic [1:0] STRAP = 2'b10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic       wr_busy = 1'b0;
    logic       byte_valid;
    logic [8:0] byte_addr;
    logic [7:0] byte_data;
    logic       mem_we = 1'b0;
    logic [8:0] mem_waddr = '0;
    logic [7:0] mem_wdata = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [16:0] exp_q[$];

    always #2.5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    twi_eeprom_engine dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .strap_i(STRAP), .wr_busy(wr_busy), .byte_valid(byte_valid),
        .byte_addr(byte_addr), .byte_data(byte_data), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    function automatic logic [7:0] ref_byte(int a);
        return 8'(a * 7 + (a >> 8) * 61 + 3);
    endfunction

    function automatic logic [7:0] dev(logic [1:0] s, logic pg, logic rw);
        return {4'b1010, s, pg, rw};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl_m = 1'b0; wt(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H);
    endtask

    task automatic put_bit(logic b);
        sda_m = b; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H / 2); b = sda_line; wt(H / 2); scl_m = 1'b0;
    endtask

    task automatic send_byte(logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~give_ack);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Scoreboard monitor: compare each write strobe with the queued expectation
    always @(negedge clk) begin
        if (rst_n && byte_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R6 actual=%0h/%0h expected=no strobe", byte_addr, byte_data);
            end else begin
                logic [16:0] e;
                e = exp_q.pop_front();
                if ({byte_addr, byte_data} !== e) begin
                    errors++;
                    $display("FAIL R6 actual=%0h expected=%0h", {byte_addr, byte_data}, e);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic a;
        logic [7:0] d;
        wt(5);
        chk("R1 reset oe", sda_oe, 0);
        chk("R6 reset strobe", byte_valid, 0);
        rst_n = 1'b1;
        wt(4);
        // preload the array through the commit port
        for (int i = 0; i < 512; i++) begin
            mem_we = 1'b1; mem_waddr = 9'(i); mem_wdata = ref_byte(i); wt(1);
        end
        mem_we = 1'b0;
        wt(4);

        // random read at 0x1F3, sequential three bytes (R3 R5 R7 R8)
        bus_start(); send_byte(dev(STRAP, 1'b1, 1'b0), a); chk("R3 dev ack", a, 1);
        send_byte(8'hF3, a); chk("R5 addr ack", a, 1);
        bus_start(); send_byte(dev(STRAP, 1'b0, 1'b1), a); chk("R3 read dev ack", a, 1);
        recv_byte(d, 1); chk("R7 random read", d, ref_byte(9'h1F3));
        recv_byte(d, 1); chk("R8 sequential 1", d, ref_byte(9'h1F4));
        recv_byte(d, 0); chk("R8 sequential 2", d, ref_byte(9'h1F5));
        bus_stop(); wt(4); chk("R1 stop release", sda_oe, 0);

        // current address read continues at last+1 (R7)
        bus_start(); send_byte(dev(STRAP, 1'b0, 1'b1), a);
        recv_byte(d, 0); chk("R7 current read", d, ref_byte(9'h1F6));
        bus_stop();

        // read wrap from last byte to 0 (R8)
        bus_start(); send_byte(dev(STRAP, 1'b1, 1'b0), a); send_byte(8'hFF, a);
        bus_start(); send_byte(dev(STRAP, 1'b0, 1'b1), a);
        recv_byte(d, 1); chk("R8 last byte", d, ref_byte(9'h1FF));
        recv_byte(d, 0); chk("R8 wrap to 0", d, ref_byte(0));
        bus_stop();

        // page write crossing the page end (R6)
        exp_q.push_back({9'h0AE, 8'h11}); exp_q.push_back({9'h0AF, 8'h22});
        exp_q.push_back({9'h0A0, 8'h33}); exp_q.push_back({9'h0A1, 8'h44});
        bus_start(); send_byte(dev(STRAP, 1'b0, 1'b0), a); send_byte(8'hAE, a);
        send_byte(8'h11, a); chk("R6 data ack", a, 1);
        send_byte(8'h22, a); send_byte(8'h33, a);
        send_byte(8'h44, a); chk("R6 data ack wrap", a, 1);
        bus_stop(); wt(4);
        chk("R6 all strobes seen", exp_q.size(), 0);
        bus_start(); send_byte(dev(STRAP, 1'b0, 1'b1), a);
        recv_byte(d, 0); chk("R6 counter after page wrap", d, ref_byte(9'h0A2));
        bus_stop();

        // strap mismatch and bad prefix (R3)
        bus_start(); send_byte(dev(2'b01, 1'b0, 1'b0), a); chk("R3 strap mismatch nak", a, 0);
        send_byte(8'h00, a); chk("R3 released after mismatch", a, 0);
        bus_stop();
        bus_start(); send_byte(8'b1011_1000, a); chk("R3 bad prefix nak", a, 0);
        bus_stop();

        // busy refusal then polling success (R4)
        wr_busy = 1'b1;
        bus_start(); send_byte(dev(STRAP, 1'b0, 1'b0), a); chk("R4 busy nak", a, 0);
        bus_stop();
        wr_busy = 1'b0;
        bus_start(); send_byte(dev(STRAP, 1'b0, 1'b1), a); chk("R4 ack after busy", a, 1);
        recv_byte(d, 0); chk("R4 read after poll", d, ref_byte(9'h0A3));
        bus_stop();

        // START mid-address aborts without loading the counter (R9)
        bus_start(); send_byte(dev(STRAP, 1'b1, 1'b0), a);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
        bus_start(); send_byte(dev(STRAP, 1'b0, 1'b1), a); chk("R9 ack after abort", a, 1);
        recv_byte(d, 0); chk("R9 counter unchanged", d, ref_byte(9'h0A4));
        bus_stop();

        // software reset during a write transfer (R10)
        bus_start(); send_byte(dev(STRAP, 1'b0, 1'b0), a); send_byte(8'h10, a);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        for (int i = 0; i < 9; i++) put_bit(1'b1);
        bus_start(); bus_stop(); wt(4);
        chk("R10 idle after reset sequence", sda_oe, 0);
        bus_start(); send_byte(dev(STRAP, 1'b0, 1'b1), a); chk("R10 ack after reset", a, 1);
        recv_byte(d, 0); chk("R10 read after reset", d, ref_byte(9'h010));
        bus_stop();

        // commit port visible to reads (R11)
        mem_we = 1'b1; mem_waddr = 9'h155; mem_wdata = 8'hC3; wt(1); mem_we = 1'b0; wt(2);
        bus_start(); send_byte(dev(STRAP, 1'b1, 1'b0), a); send_byte(8'h55, a);
        bus_start(); send_byte(dev(STRAP, 1'b0, 1'b1), a);
        recv_byte(d, 0); chk("R11 committed byte", d, 8'hC3);
        bus_stop(); wt(8);
        chk("R6 no stray strobes", exp_q.size(), 0);

        done = 1;
        finish_run();
    end

endmodule